// File: doc/BRIEF.md
# Condition Code Byte Evaluator

This unit turns a four-bit condition selector and five status flags (overflow, carry, zero, sign, parity) into a byte that is 8'h01 when the selected condition holds and 8'h00 when it does not. It then delivers that byte as a write request. A register-direct addressing mode sends it to an 8-bit register-file write port. Every other mode sends it to a memory write port at the supplied effective address.

A request is presented for one cycle with `req_valid`. The byte, the destination index or address, and a one-cycle write strobe appear after the next rising clock edge. Requests may arrive on consecutive cycles, and each one produces its own strobe. The unit has no state machine. Its only state is one output register stage, which has two conditions: idle, where both strobes are low, and issuing, where exactly one strobe is high. Going from idle to issuing takes one cycle with a request. Going from issuing back to idle takes one cycle without a request, or a reset.

Top module: `ccb_eval`

## Requirements
- R1: While `rst` is high at a rising edge, both write strobes and the data byte are cleared after that edge.
- R2: For every even selector s, the selector s+1 yields the logical inverse of s under the same flags. Selector bit 0 selects the negated form.
- R3: Selector 0 is true when overflow is set, 2 when carry is set, 4 when zero is set, 8 when sign is set, and 10 when parity is set.
- R4: Selector 6 (below-or-equal) is true when carry or zero is set. Selector 7 is true only when both are clear.
- R5: Selector 12 (less) is true when sign differs from overflow. Selector 13 is true when they are equal.
- R6: Selector 14 (less-or-equal) is true when zero is set or sign differs from overflow. Selector 15 needs zero clear and sign equal to overflow.
- R7: The written byte is always 8'h00 or 8'h01, so bits 7..1 are zero.
- R8: A request accepted at a rising edge raises exactly one strobe for the cycle after that edge. Back-to-back requests give back-to-back strobes.
- R9: Mode 2'b11 (register direct) raises `reg_we` with `reg_waddr` equal to the request's register index. Modes 2'b00, 2'b01 and 2'b10 raise `mem_we` with `mem_waddr` equal to the request's address. The two strobes are never high together.
- R10: A cycle without `req_valid` raises no strobe, whatever the flags and selector are.
- R11: Reset has priority over a request that arrives in the same cycle. No strobe follows that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| cond_sel | input | 4 | Condition selector |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| addr_mode | input | MODE_W (2) | Addressing mode; all ones means register direct |
| reg_idx | input | REG_IDX_W (3) | Destination register index |
| mem_addr | input | ADDR_W (16) | Destination effective address |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | REG_IDX_W (3) | Register write index |
| reg_wdata | output | 8 | Register write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W (16) | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
A new request and the retirement of the previous one always share a cycle. The sweep issues every selector and flag combination back to back while the mode alternates between register and memory. This shows one strobe dropping exactly as the other rises, and never both high together. Reset and a request are also driven in the same cycle, and the cycle that follows is judged to carry no strobe. The next request is judged to issue normally.

// File: rtl/ccb_pkg.sv
`timescale 1ns/1ps
package ccb_pkg;

    // Selector codes; bit 0 picks the negated member of each pair.
    typedef enum logic [3:0] {
        CC_O   = 4'd0,  CC_NO  = 4'd1,
        CC_B   = 4'd2,  CC_NB  = 4'd3,
        CC_Z   = 4'd4,  CC_NZ  = 4'd5,
        CC_BE  = 4'd6,  CC_NBE = 4'd7,
        CC_S   = 4'd8,  CC_NS  = 4'd9,
        CC_P   = 4'd10, CC_NP  = 4'd11,
        CC_L   = 4'd12, CC_NL  = 4'd13,
        CC_LE  = 4'd14, CC_NLE = 4'd15
    } cc_sel_e;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zer;
        logic sgn;
        logic par;
    } cc_flags_t;

    localparam int CC_SEL_W  = 4;
    localparam int CC_PAIRS  = 8;
    localparam int CC_COUNT  = 2 * CC_PAIRS;
    localparam int CC_BYTE_W = 8;

endpackage

// File: rtl/ccb_cond_decode.sv
`timescale 1ns/1ps
module ccb_cond_decode
    import ccb_pkg::*;
(
    input  cc_flags_t             flags,
    input  logic [CC_SEL_W-1:0]   sel,
    output logic                  hit
);

    logic [CC_PAIRS-1:0] pair_true;
    logic [CC_COUNT-1:0] all_cond;
    logic                signed_lt;

    always_comb begin
        signed_lt    = flags.sgn ^ flags.ovf;
        pair_true[0] = flags.ovf;
        pair_true[1] = flags.cry;
        pair_true[2] = flags.zer;
        pair_true[3] = flags.cry | flags.zer;
        pair_true[4] = flags.sgn;
        pair_true[5] = flags.par;
        pair_true[6] = signed_lt;
        pair_true[7] = flags.zer | signed_lt;
    end

    // Each pair expands into a true form and its complement.
    for (genvar g = 0; g < CC_PAIRS; g++) begin : g_pair
        assign all_cond[2*g]   =  pair_true[g];
        assign all_cond[2*g+1] = ~pair_true[g];
    end

    assign hit = all_cond[sel];

endmodule

// File: rtl/ccb_dest_steer.sv
`timescale 1ns/1ps
module ccb_dest_steer #(
    parameter int MODE_W = 2
) (
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    output logic              to_reg,
    output logic              to_mem
);

    localparam logic [MODE_W-1:0] REG_DIRECT = '1;

    logic is_reg;

    always_comb begin
        is_reg = (mode == REG_DIRECT);
        to_reg = req &  is_reg;
        to_mem = req & ~is_reg;
    end

endmodule

// File: rtl/ccb_eval.sv
`timescale 1ns/1ps
module ccb_eval
    import ccb_pkg::*;
#(
    parameter int MODE_W    = 2,
    parameter int REG_IDX_W = 3,
    parameter int ADDR_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [3:0]            cond_sel,
    input  logic                  flag_of,
    input  logic                  flag_cf,
    input  logic                  flag_zf,
    input  logic                  flag_sf,
    input  logic                  flag_pf,
    input  logic [MODE_W-1:0]     addr_mode,
    input  logic [REG_IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0]     mem_addr,
    output logic                  reg_we,
    output logic [REG_IDX_W-1:0]  reg_waddr,
    output logic [7:0]            reg_wdata,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_waddr,
    output logic [7:0]            mem_wdata
);

    localparam int PAD_W = CC_BYTE_W - 1;

    cc_flags_t          flags;
    logic               cond_hit;
    logic               go_reg;
    logic               go_mem;
    logic [CC_BYTE_W-1:0] byte_q;

    assign flags = '{ovf: flag_of, cry: flag_cf, zer: flag_zf,
                     sgn: flag_sf, par: flag_pf};

    ccb_cond_decode u_decode (
        .flags (flags),
        .sel   (cond_sel),
        .hit   (cond_hit)
    );

    ccb_dest_steer #(.MODE_W(MODE_W)) u_steer (
        .req    (req_valid),
        .mode   (addr_mode),
        .to_reg (go_reg),
        .to_mem (go_mem)
    );

    // Single output stage: strobes live one cycle per request.
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we    <= 1'b0;
            mem_we    <= 1'b0;
            byte_q    <= '0;
            reg_waddr <= '0;
            mem_waddr <= '0;
        end else begin
            reg_we <= go_reg;
            mem_we <= go_mem;
            if (req_valid) begin
                byte_q <= {{PAD_W{1'b0}}, cond_hit};
            end
            if (go_reg) begin
                reg_waddr <= reg_idx;
            end
            if (go_mem) begin
                mem_waddr <= mem_addr;
            end
        end
    end

    assign reg_wdata = byte_q;
    assign mem_wdata = byte_q;

endmodule

// File: rtl/ccb_eval_chk.sv
`timescale 1ns/1ps
module ccb_eval_chk #(
    parameter int MODE_W    = 2,
    parameter int REG_IDX_W = 3,
    parameter int ADDR_W    = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [3:0]            cond_sel,
    input logic                  flag_of,
    input logic                  flag_cf,
    input logic                  flag_zf,
    input logic                  flag_sf,
    input logic                  flag_pf,
    input logic [MODE_W-1:0]     addr_mode,
    input logic [REG_IDX_W-1:0]  reg_idx,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic                  reg_we,
    input logic [REG_IDX_W-1:0]  reg_waddr,
    input logic [7:0]            reg_wdata,
    input logic                  mem_we,
    input logic [ADDR_W-1:0]     mem_waddr,
    input logic [7:0]            mem_wdata
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!reg_we && !mem_we && reg_wdata == 8'h00));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, mem_we}));

    assert_reg_route_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr_mode == '1) |=> (reg_we && reg_waddr == $past(reg_idx)));

    assert_mem_route_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr_mode != '1) |=> (mem_we && mem_waddr == $past(mem_addr)));

    assert_strobe_per_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (reg_we || mem_we));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!reg_we && !mem_we));

    assert_byte_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_we || mem_we) |-> (reg_wdata[7:1] == 7'd0 && mem_wdata[7:1] == 7'd0));

    assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cond_sel == 4'd2) |=> (reg_wdata[0] == $past(flag_cf)));

    assert_below_eq_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cond_sel == 4'd7) |=> (reg_wdata[0] == !($past(flag_cf) || $past(flag_zf))));

    assert_less_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cond_sel == 4'd12) |=> (mem_wdata[0] == ($past(flag_sf) != $past(flag_of))));

    assert_less_eq_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cond_sel == 4'd14)
            |=> (mem_wdata[0] == ($past(flag_zf) || ($past(flag_sf) != $past(flag_of)))));

    assert_parity_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cond_sel == 4'd11) |=> (reg_wdata[0] == !$past(flag_pf)));

endmodule

bind ccb_eval ccb_eval_chk #(
    .MODE_W    (MODE_W),
    .REG_IDX_W (REG_IDX_W),
    .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/test_ccb_eval.sv
`timescale 1ns/1ps
module test_ccb_eval;

    localparam int MODE_W    = 2;
    localparam int REG_IDX_W = 3;
    localparam int ADDR_W    = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [3:0]           cond_sel = '0;
    logic                 flag_of = 1'b0, flag_cf = 1'b0, flag_zf = 1'b0;
    logic                 flag_sf = 1'b0, flag_pf = 1'b0;
    logic [MODE_W-1:0]    addr_mode = '0;
    logic [REG_IDX_W-1:0] reg_idx = '0;
    logic [ADDR_W-1:0]    mem_addr = '0;
    logic                 reg_we, mem_we;
    logic [REG_IDX_W-1:0] reg_waddr;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [7:0]           reg_wdata, mem_wdata;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    ccb_eval #(.MODE_W(MODE_W), .REG_IDX_W(REG_IDX_W), .ADDR_W(ADDR_W)) i_ccb_eval (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cond_sel(cond_sel),
        .flag_of(flag_of), .flag_cf(flag_cf), .flag_zf(flag_zf),
        .flag_sf(flag_sf), .flag_pf(flag_pf), .addr_mode(addr_mode),
        .reg_idx(reg_idx), .mem_addr(mem_addr),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected truth from the requirement wording, flags packed {of,cf,zf,sf,pf}.
    function automatic logic expect_cond(input int sel, input logic [4:0] f);
        logic o, c, z, s, p, t;
        {o, c, z, s, p} = f;
        case (sel / 2)
            0: t = o;
            1: t = c;
            2: t = z;
            3: t = (c + z) != 0;
            4: t = s;
            5: t = p;
            6: t = (s != o);
            default: t = z || (s != o);
        endcase
        return (sel % 2 == 1) ? !t : t;
    endfunction

    function automatic string tag_for(input int sel);
        if (sel % 2 == 1)                 return "R2";
        if (sel == 6)                     return "R4";
        if (sel == 12)                    return "R5";
        if (sel == 14)                    return "R6";
        return "R3";
    endfunction

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 strobes", {30'd0, reg_we, mem_we}, 32'd0);
        chk("R1 data", {24'd0, reg_wdata}, 32'd0);
        rst = 1'b0;

        // Back-to-back sweep of every selector, flag set and both destinations.
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 32; f++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [4:0]  fl;
                    logic [1:0]  md;
                    logic [2:0]  ri;
                    logic [15:0] ma;
                    logic        e;
                    fl = f[4:0];
                    md = (m == 1) ? 2'b11 : 2'((s + f) % 3);
                    ri = f[2:0] ^ s[2:0];
                    ma = 16'((s << 8) | (f << 1) | m) ^ 16'hA500;
                    e  = expect_cond(s, fl);
                    req_valid = 1'b1;
                    cond_sel  = s[3:0];
                    {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = fl;
                    addr_mode = md;
                    reg_idx   = ri;
                    mem_addr  = ma;
                    @(negedge clk);
                    chk(tag_for(s), {31'd0, reg_wdata[0]}, {31'd0, e});
                    chk("R7", {25'd0, reg_wdata[7:1]}, 32'd0);
                    if (md == 2'b11) begin
                        chk("R9 reg strobe", {30'd0, reg_we, mem_we}, 32'd2);
                        chk("R9 reg index", {29'd0, reg_waddr}, {29'd0, ri});
                    end else begin
                        chk("R9 mem strobe", {30'd0, reg_we, mem_we}, 32'd1);
                        chk("R9 mem addr", {16'd0, mem_waddr}, {16'd0, ma});
                        chk("R7 mem byte", {24'd0, mem_wdata}, {31'd0, e});
                    end
                end
            end
        end

        // R8: strobe ends one cycle after the last request.
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 strobe drop", {30'd0, reg_we, mem_we}, 32'd0);

        // R10: flags and selector toggling without a request.
        for (int k = 0; k < 4; k++) begin
            cond_sel = 4'(k * 5);
            {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = 5'(k * 7 + 3);
            addr_mode = 2'(k);
            @(negedge clk);
            chk("R10 idle", {30'd0, reg_we, mem_we}, 32'd0);
        end

        // R11: reset and request in the same cycle.
        req_valid = 1'b1;
        cond_sel  = 4'd4;
        {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = 5'b00100;
        addr_mode = 2'b11;
        reg_idx   = 3'd5;
        rst       = 1'b1;
        @(negedge clk);
        chk("R11 no strobe", {30'd0, reg_we, mem_we}, 32'd0);
        chk("R11 data cleared", {24'd0, reg_wdata}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 after reset", {30'd0, reg_we, mem_we}, 32'd2);
        chk("R3 zero after reset", {24'd0, reg_wdata}, 32'd1);
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule